// File: doc/BRIEF.md
# IOVA Window Gate

This block is the first stage of a small I/O memory-management unit. Every device request carries an address and a read/write flag. In one registered cycle the gate decides whether the request goes through untranslated, goes on to the translation stage, or is a fault. A faulting request is either aborted or steered to a default 4 KB page. The gate also receives fault reports from the translation stage: one class for a missing or invalid entry, another for a write to a read-only page.

There are three fault classes: window overrun, invalid entry and write to a read-only page. Each class has its own sticky flag and its own enables for an abort pulse, an exception pulse and a level interrupt. The page number of the first violating address is kept until software clears every flag. Configuration sits in six 32-bit registers on a simple register bus. The bus has a write strobe, a read strobe and a read response one cycle later.

The translation window is bounded by a cap counted in 256 MB units, and the value written is the last legal unit. A bypass range lets low addresses through untranslated. The bypass range is counted in 256 MB units, or in 4 MB units when the `BIG_BYP` parameter is 1.

Top module: `iova_gate`

## Requirements
- R1: After reset every register reads 0, and `rsp_valid`, `abort`, `exc` and `irq` are 0.
- R2: When the control register has enable (bit 0) at 0 or pass-all (bit 1) at 1, a request comes out one cycle later as route 0 (pass) with its address unchanged. No fault of any class is recorded and no pulse is raised.
- R3: The bypass-low register at 0x08 holds enable (bit 31), invert (bit 30) and a limit in the low bits. The bypass-high register at 0x0C holds enable (bit 31) and a limit. The address unit is `addr >> 28`, or `addr >> 22` when `BIG_BYP`=1. An address is inside the range if at least one bound is enabled, unit >= low limit (when that bound is enabled) and unit < high limit (when that bound is enabled). It bypasses (route 0) when inside XOR invert is 1.
- R4: The cap register at 0x04 holds enable (bit 31) and a limit in the low bits. A request that does not bypass, with the cap enabled and `addr >> 28` greater than the limit, is a window-overrun fault. Any other request that does not bypass goes out as route 1 (translate) with its address unchanged.
- R5: A window-overrun fault goes out as route 3 (abort) when its abort enable is set or the default page is disabled. Otherwise it goes out as route 2 (redirect), with address {default page, request bits 11:0}. The default-page register at 0x10 holds enable (bit 31) and the page number in the low bits.
- R6: Control register fields for class c (0 = overrun, 1 = invalid entry, 2 = write to read-only) start at bit 8+4c: +0 exception enable, +1 interrupt enable, +2 abort enable, +3 sticky flag. A recorded fault sets its flag. Writing 1 to a flag bit clears it, and a fault in the same cycle wins over the clear.
- R7: `abort` and `exc` are one-cycle pulses. They appear in the same cycle that a newly recorded fault's flag becomes visible, for each class whose abort or exception enable is set.
- R8: `irq` is high exactly while some sticky flag is set together with that class's interrupt enable.
- R9: The register at 0x14 reads the page number (address >> 12) of a faulting access. It loads only when a fault is recorded while no flag is set. A window-overrun fault takes precedence over a translation-stage fault in the same cycle.
- R10: A translation-stage report with `tx_flt_kind`=0 (invalid entry) is recorded only when check-enable (control bit 2) is set. A report with `tx_flt_kind`=1 (write to read-only) is always recorded while the gate is active.
- R11: A register read returns its data with `reg_rvalid` one cycle after `reg_rd`. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid |
| req_valid | input | 1 | Device request valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | AW | Request address |
| tx_flt_valid | input | 1 | Fault report from translation stage |
| tx_flt_kind | input | 1 | 0 invalid entry, 1 write to read-only |
| tx_flt_addr | input | AW | Address of the reported fault |
| rsp_valid | output | 1 | Classified request valid |
| rsp_write | output | 1 | Forwarded write flag |
| rsp_route | output | 2 | 0 pass, 1 translate, 2 redirect, 3 abort |
| rsp_addr | output | AW | Forwarded or redirected address |
| abort | output | 1 | Abort pulse |
| exc | output | 1 | Exception pulse |
| irq | output | 1 | Interrupt level |

## Verification
Several rules are checked by assertions on every cycle:
- each request yields a response one cycle later;
- pass-route responses keep their address, and redirects keep their page offset;
- nothing faults while the gate is off;
- pulses and the interrupt never appear without a sticky flag;
- a flag falls only through a clear;
- the captured page holds while any flag is set.

Other behaviour only the bench's scenarios can show:
- exact unit boundaries of the bypass range and the cap;
- the choice between redirect and abort;
- gating of invalid-entry reports by check-enable;
- correct register readback.

// File: rtl/iova_gate_pkg.sv
package iova_gate_pkg;
  typedef enum logic [1:0] {
    RT_PASS  = 2'd0,
    RT_XLATE = 2'd1,
    RT_REDIR = 2'd2,
    RT_ABORT = 2'd3
  } route_e;

  localparam int NCLS    = 3;
  localparam int CLS_CAP = 0;
  localparam int CLS_INV = 1;
  localparam int CLS_WRO = 2;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CAP  = 8'h04;
  localparam logic [7:0] A_BLO  = 8'h08;
  localparam logic [7:0] A_BHI  = 8'h0C;
  localparam logic [7:0] A_DFLT = 8'h10;
  localparam logic [7:0] A_VIO  = 8'h14;

  localparam int B_EN       = 0;
  localparam int B_PASSALL  = 1;
  localparam int B_INVCHK   = 2;
  localparam int B_CLS0     = 8;
  localparam int CLS_STRIDE = 4;
  localparam int F_EXC      = 0;
  localparam int F_IRQ      = 1;
  localparam int F_ABT      = 2;
  localparam int F_STK      = 3;

  localparam int PG_SH  = 12;
  localparam int CAP_SH = 28;
  localparam int BIG_SH = 22;
endpackage

// File: rtl/iova_gate_regs.sv
module iova_gate_regs
  import iova_gate_pkg::*;
#(
  parameter int AW    = 36,
  parameter int BYP_W = 8,
  parameter int CAP_W = 8,
  localparam int PG_W = AW - PG_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid,
  input  logic [NCLS-1:0]  sticky,
  input  logic [PG_W-1:0]  vio_pg,
  output logic             en,
  output logic             pass_all,
  output logic             inv_chk,
  output logic [NCLS-1:0]  exc_en,
  output logic [NCLS-1:0]  irq_en,
  output logic [NCLS-1:0]  abt_en,
  output logic [NCLS-1:0]  clr,
  output logic             cap_en,
  output logic [CAP_W-1:0] cap_lim,
  output logic             blo_en,
  output logic             blo_inv,
  output logic [BYP_W-1:0] blo_lim,
  output logic             bhi_en,
  output logic [BYP_W-1:0] bhi_lim,
  output logic             dflt_en,
  output logic [PG_W-1:0]  dflt_pg
);
  logic        wr_ctrl;
  logic [31:0] rd_mux;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  always_comb begin
    for (int c = 0; c < NCLS; c++)
      clr[c] = wr_ctrl && reg_wdata[B_CLS0 + CLS_STRIDE*c + F_STK];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; pass_all <= 1'b0; inv_chk <= 1'b0;
      exc_en <= '0; irq_en <= '0; abt_en <= '0;
      cap_en <= 1'b0; cap_lim <= '0;
      blo_en <= 1'b0; blo_inv <= 1'b0; blo_lim <= '0;
      bhi_en <= 1'b0; bhi_lim <= '0;
      dflt_en <= 1'b0; dflt_pg <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          en       <= reg_wdata[B_EN];
          pass_all <= reg_wdata[B_PASSALL];
          inv_chk  <= reg_wdata[B_INVCHK];
          for (int c = 0; c < NCLS; c++) begin
            exc_en[c] <= reg_wdata[B_CLS0 + CLS_STRIDE*c + F_EXC];
            irq_en[c] <= reg_wdata[B_CLS0 + CLS_STRIDE*c + F_IRQ];
            abt_en[c] <= reg_wdata[B_CLS0 + CLS_STRIDE*c + F_ABT];
          end
        end
        A_CAP: begin
          cap_en  <= reg_wdata[31];
          cap_lim <= reg_wdata[CAP_W-1:0];
        end
        A_BLO: begin
          blo_en  <= reg_wdata[31];
          blo_inv <= reg_wdata[30];
          blo_lim <= reg_wdata[BYP_W-1:0];
        end
        A_BHI: begin
          bhi_en  <= reg_wdata[31];
          bhi_lim <= reg_wdata[BYP_W-1:0];
        end
        A_DFLT: begin
          dflt_en <= reg_wdata[31];
          dflt_pg <= reg_wdata[PG_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[B_EN]      = en;
        rd_mux[B_PASSALL] = pass_all;
        rd_mux[B_INVCHK]  = inv_chk;
        for (int c = 0; c < NCLS; c++) begin
          rd_mux[B_CLS0 + CLS_STRIDE*c + F_EXC] = exc_en[c];
          rd_mux[B_CLS0 + CLS_STRIDE*c + F_IRQ] = irq_en[c];
          rd_mux[B_CLS0 + CLS_STRIDE*c + F_ABT] = abt_en[c];
          rd_mux[B_CLS0 + CLS_STRIDE*c + F_STK] = sticky[c];
        end
      end
      A_CAP: begin
        rd_mux[31]        = cap_en;
        rd_mux[CAP_W-1:0] = cap_lim;
      end
      A_BLO: begin
        rd_mux[31]        = blo_en;
        rd_mux[30]        = blo_inv;
        rd_mux[BYP_W-1:0] = blo_lim;
      end
      A_BHI: begin
        rd_mux[31]        = bhi_en;
        rd_mux[BYP_W-1:0] = bhi_lim;
      end
      A_DFLT: begin
        rd_mux[31]       = dflt_en;
        rd_mux[PG_W-1:0] = dflt_pg;
      end
      A_VIO: rd_mux[PG_W-1:0] = vio_pg;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rdata  <= reg_rd ? rd_mux : '0;
      reg_rvalid <= reg_rd;
    end
  end
endmodule

// File: rtl/iova_gate_window.sv
module iova_gate_window
  import iova_gate_pkg::*;
#(
  parameter int AW     = 36,
  parameter int BYP_SH = 28,
  localparam int BYP_W = AW - BYP_SH,
  localparam int CAP_W = AW - CAP_SH
) (
  input  logic [AW-1:0]    addr,
  input  logic             cap_en,
  input  logic [CAP_W-1:0] cap_lim,
  input  logic             blo_en,
  input  logic             blo_inv,
  input  logic [BYP_W-1:0] blo_lim,
  input  logic             bhi_en,
  input  logic [BYP_W-1:0] bhi_lim,
  output logic             bypass,
  output logic             cap_over
);
  logic [BYP_W-1:0] unit;
  logic [1:0]       bound_ok;

  assign unit = addr[AW-1:BYP_SH];

  for (genvar b = 0; b < 2; b++) begin : g_bound
    if (b == 0) begin : g_lo
      assign bound_ok[b] = !blo_en || (unit >= blo_lim);
    end else begin : g_hi
      assign bound_ok[b] = !bhi_en || (unit < bhi_lim);
    end
  end

  assign bypass   = (blo_en || bhi_en) && ((&bound_ok) ^ blo_inv);
  assign cap_over = cap_en && (addr[AW-1:CAP_SH] > cap_lim);
endmodule

// File: rtl/iova_gate_fault.sv
module iova_gate_fault
  import iova_gate_pkg::*;
#(
  parameter int AW = 36,
  localparam int PG_W = AW - PG_SH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] hit,
  input  logic [PG_W-1:0] hit_pg,
  input  logic [NCLS-1:0] exc_en,
  input  logic [NCLS-1:0] irq_en,
  input  logic [NCLS-1:0] abt_en,
  input  logic [NCLS-1:0] clr,
  output logic [NCLS-1:0] sticky,
  output logic [PG_W-1:0] vio_pg,
  output logic            abort,
  output logic            exc,
  output logic            irq
);
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst)         sticky[c] <= 1'b0;
      else if (hit[c]) sticky[c] <= 1'b1;
      else if (clr[c]) sticky[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vio_pg <= '0;
      abort  <= 1'b0;
      exc    <= 1'b0;
    end else begin
      if ((|hit) && !(|sticky)) vio_pg <= hit_pg;
      abort <= |(hit & abt_en);
      exc   <= |(hit & exc_en);
    end
  end

  assign irq = |(sticky & irq_en);
endmodule

// File: rtl/iova_gate.sv
module iova_gate
  import iova_gate_pkg::*;
#(
  parameter int AW      = 36,
  parameter bit BIG_BYP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          tx_flt_valid,
  input  logic          tx_flt_kind,
  input  logic [AW-1:0] tx_flt_addr,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic [1:0]    rsp_route,
  output logic [AW-1:0] rsp_addr,
  output logic          abort,
  output logic          exc,
  output logic          irq
);
  localparam int BYP_SH = BIG_BYP ? BIG_SH : CAP_SH;
  localparam int BYP_W  = AW - BYP_SH;
  localparam int CAP_W  = AW - CAP_SH;
  localparam int PG_W   = AW - PG_SH;

  logic             cfg_en, cfg_pass_all, cfg_inv_chk;
  logic [NCLS-1:0]  cfg_exc_en, cfg_irq_en, cfg_abt_en, cfg_clr;
  logic             cfg_cap_en, cfg_blo_en, cfg_blo_inv, cfg_bhi_en, cfg_dflt_en;
  logic [CAP_W-1:0] cfg_cap_lim;
  logic [BYP_W-1:0] cfg_blo_lim, cfg_bhi_lim;
  logic [PG_W-1:0]  cfg_dflt_pg;
  logic [NCLS-1:0]  flt_sticky;
  logic [PG_W-1:0]  flt_vio_pg;
  logic             win_bypass, win_cap_over;
  logic             active;
  logic [NCLS-1:0]  hit;
  logic [PG_W-1:0]  hit_pg;
  route_e           route_d;
  logic [AW-1:0]    addr_d;

  iova_gate_regs #(.AW(AW), .BYP_W(BYP_W), .CAP_W(CAP_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .sticky(flt_sticky), .vio_pg(flt_vio_pg),
    .en(cfg_en), .pass_all(cfg_pass_all), .inv_chk(cfg_inv_chk),
    .exc_en(cfg_exc_en), .irq_en(cfg_irq_en), .abt_en(cfg_abt_en), .clr(cfg_clr),
    .cap_en(cfg_cap_en), .cap_lim(cfg_cap_lim),
    .blo_en(cfg_blo_en), .blo_inv(cfg_blo_inv), .blo_lim(cfg_blo_lim),
    .bhi_en(cfg_bhi_en), .bhi_lim(cfg_bhi_lim),
    .dflt_en(cfg_dflt_en), .dflt_pg(cfg_dflt_pg)
  );

  iova_gate_window #(.AW(AW), .BYP_SH(BYP_SH)) u_win (
    .addr(req_addr),
    .cap_en(cfg_cap_en), .cap_lim(cfg_cap_lim),
    .blo_en(cfg_blo_en), .blo_inv(cfg_blo_inv), .blo_lim(cfg_blo_lim),
    .bhi_en(cfg_bhi_en), .bhi_lim(cfg_bhi_lim),
    .bypass(win_bypass), .cap_over(win_cap_over)
  );

  assign active = cfg_en && !cfg_pass_all;

  always_comb begin
    hit          = '0;
    hit[CLS_CAP] = req_valid && active && !win_bypass && win_cap_over;
    hit[CLS_INV] = tx_flt_valid && active && cfg_inv_chk && !tx_flt_kind;
    hit[CLS_WRO] = tx_flt_valid && active && tx_flt_kind;
    hit_pg       = hit[CLS_CAP] ? req_addr[AW-1:PG_SH] : tx_flt_addr[AW-1:PG_SH];
  end

  always_comb begin
    route_d = RT_XLATE;
    addr_d  = req_addr;
    if (!active || win_bypass) begin
      route_d = RT_PASS;
    end else if (win_cap_over) begin
      if (cfg_abt_en[CLS_CAP] || !cfg_dflt_en) begin
        route_d = RT_ABORT;
        addr_d  = '0;
      end else begin
        route_d = RT_REDIR;
        addr_d  = {cfg_dflt_pg, req_addr[PG_SH-1:0]};
      end
    end
  end

  iova_gate_fault #(.AW(AW)) u_flt (
    .clk(clk), .rst(rst),
    .hit(hit), .hit_pg(hit_pg),
    .exc_en(cfg_exc_en), .irq_en(cfg_irq_en), .abt_en(cfg_abt_en), .clr(cfg_clr),
    .sticky(flt_sticky), .vio_pg(flt_vio_pg),
    .abort(abort), .exc(exc), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_route <= RT_PASS;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_write <= req_valid && req_write;
      if (req_valid) begin
        rsp_route <= route_d;
        rsp_addr  <= addr_d;
      end
    end
  end
endmodule

// File: rtl/iova_gate_chk.sv
module iova_gate_chk
  import iova_gate_pkg::*;
#(
  parameter int AW = 36,
  localparam int PG_W = AW - PG_SH
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic [1:0]      rsp_route,
  input logic [AW-1:0]   rsp_addr,
  input logic            abort,
  input logic            exc,
  input logic            irq,
  input logic            en,
  input logic            pass_all,
  input logic [NCLS-1:0] sticky,
  input logic [NCLS-1:0] clr,
  input logic [PG_W-1:0] vio_pg,
  input logic            reg_rd,
  input logic            reg_rvalid
);
  p_rsp_follow_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_pass_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == RT_PASS) |-> rsp_addr == $past(req_addr));
  p_off_nofault_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!en || pass_all)) |=> (rsp_route == RT_PASS && !abort && !exc));
  p_redir_offset_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == RT_REDIR) |-> rsp_addr[PG_SH-1:0] == $past(req_addr[PG_SH-1:0]));
  p_pulse_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (abort || exc) |-> sticky != '0);
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (sticky == '0) |-> !irq);
  p_vio_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (|$past(sticky)) |-> vio_pg == $past(vio_pg));
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  for (genvar c = 0; c < NCLS; c++) begin : g_clr
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(sticky[c]) |-> $past(clr[c]));
  end
endmodule

bind iova_gate iova_gate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_addr(rsp_addr),
  .abort(abort), .exc(exc), .irq(irq),
  .en(cfg_en), .pass_all(cfg_pass_all),
  .sticky(flt_sticky), .clr(cfg_clr), .vio_pg(flt_vio_pg),
  .reg_rd(reg_rd), .reg_rvalid(reg_rvalid)
);

// File: tb/sim_iova_gate.sv
module sim_iova_gate;
  localparam int AW = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_rvalid;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          tx_flt_valid = 1'b0, tx_flt_kind = 1'b0;
  logic [AW-1:0] tx_flt_addr = '0;
  logic          rsp_valid, rsp_write;
  logic [1:0]    rsp_route;
  logic [AW-1:0] rsp_addr;
  logic          abort, exc, irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  iova_gate u0 (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .tx_flt_valid(tx_flt_valid), .tx_flt_kind(tx_flt_kind), .tx_flt_addr(tx_flt_addr),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_route(rsp_route), .rsp_addr(rsp_addr),
    .abort(abort), .exc(exc), .irq(irq)
  );

  // {address, expected route, expected address, expected irq}
  localparam int NV = 6;
  localparam logic [74:0] VEC [NV] = '{
    {36'h0_1234_5678, 2'd0, 36'h0_1234_5678, 1'b0},
    {36'h9_FFFF_FFFC, 2'd0, 36'h9_FFFF_FFFC, 1'b0},
    {36'hA_0000_0000, 2'd1, 36'hA_0000_0000, 1'b0},
    {36'hA_7FFF_F123, 2'd1, 36'hA_7FFF_F123, 1'b0},
    {36'hA_8000_0456, 2'd2, 36'h0_00AB_C456, 1'b1},
    {36'hF_FFFF_FFFF, 2'd2, 36'h0_00AB_CFFF, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic req(input logic [AW-1:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic txf(input logic kind, input logic [AW-1:0] a);
    @(negedge clk);
    tx_flt_valid = 1'b1; tx_flt_kind = kind; tx_flt_addr = a;
    @(negedge clk);
    tx_flt_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 abort", abort, 0);
    chk("R1 irq", irq, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    chk("R11 rvalid", reg_rvalid, 1);
    rd(8'h04, d); chk("R1 cap", d, 0);

    // configuration: window up to unit A7, bypass below unit A0, default page ABC
    wr(8'h04, 32'h8000_00A7);
    wr(8'h08, 32'h8000_0000);
    wr(8'h0C, 32'h8000_00A0);
    wr(8'h10, 32'h8000_0ABC);
    wr(8'h00, 32'h0000_0201);

    // R3 R4 R5 R8 table walk
    for (int i = 0; i < NV; i++) begin
      req(VEC[i][74:39], i[0]);
      chk("R3/R4/R5 route", rsp_route, VEC[i][38:37]);
      chk("R3/R4/R5 addr", rsp_addr, VEC[i][36:1]);
      chk("R7 no abort", abort, 0);
      chk("R8 irq", irq, VEC[i][0]);
    end
    rd(8'h00, d); chk("R6 flag set", d, 32'h0000_0A01);
    rd(8'h14, d); chk("R9 first page", d, 32'h00A8_0000);

    // R6 write-one-to-clear
    wr(8'h00, 32'h0000_0A01);
    rd(8'h00, d); chk("R6 cleared", d, 32'h0000_0201);
    chk("R8 irq low", irq, 0);

    // R5 R7 abort route and pulse
    wr(8'h00, 32'h0000_0E01);
    req(36'hB_0000_0000, 1'b0);
    chk("R5 abort route", rsp_route, 3);
    chk("R7 abort pulse", abort, 1);
    @(negedge clk);
    chk("R7 abort ends", abort, 0);
    rd(8'h14, d); chk("R9 recapture", d, 32'h00B0_0000);

    // R10 invalid-entry ignored while check disabled
    wr(8'h00, 32'h0000_0801);
    rd(8'h00, d); chk("R6 clear", d, 32'h0000_0001);
    txf(1'b0, 36'h2_0000_1000);
    chk("R10 no exc", exc, 0);
    rd(8'h00, d); chk("R10 no flag", d, 32'h0000_0001);
    rd(8'h14, d); chk("R10 page kept", d, 32'h00B0_0000);

    // R10 R7 invalid-entry recorded with check enabled
    wr(8'h00, 32'h0000_1005);
    txf(1'b0, 36'h2_0000_1000);
    chk("R7 exc pulse", exc, 1);
    chk("R7 no abort", abort, 0);
    rd(8'h00, d); chk("R10 flag", d, 32'h0000_9005);
    rd(8'h14, d); chk("R9 page", d, 32'h0020_0001);

    // R9 second fault keeps first page
    txf(1'b1, 36'h1_2345_6000);
    rd(8'h00, d); chk("R6 wro flag", d, 32'h0008_9005);
    rd(8'h14, d); chk("R9 hold", d, 32'h0020_0001);
    chk("R8 no irq", irq, 0);
    wr(8'h00, 32'h0008_9005);
    rd(8'h00, d); chk("R6 both cleared", d, 32'h0000_1005);

    // R2 disabled and pass-all
    wr(8'h00, 32'h0000_0000);
    req(36'hF_0000_0000, 1'b1);
    chk("R2 off route", rsp_route, 0);
    chk("R2 off addr", rsp_addr, 36'hF_0000_0000);
    chk("R2 off abort", abort, 0);
    rd(8'h00, d); chk("R2 off noflag", d, 0);
    wr(8'h00, 32'h0000_0003);
    req(36'hF_0000_0000, 1'b0);
    chk("R2 passall route", rsp_route, 0);
    rd(8'h00, d); chk("R2 passall noflag", d, 32'h0000_0003);

    // R3 inverted bypass range
    wr(8'h00, 32'h0000_0001);
    wr(8'h08, 32'hC000_0000);
    req(36'h0_1234_5678, 1'b0);
    chk("R3 invert inside", rsp_route, 1);
    req(36'hA_0000_0000, 1'b0);
    chk("R3 invert outside", rsp_route, 0);

    // R11 readback and unmapped offset
    rd(8'h04, d); chk("R11 cap readback", d, 32'h8000_00A7);
    rd(8'h08, d); chk("R11 blo readback", d, 32'hC000_0000);
    rd(8'h3C, d); chk("R11 unmapped", d, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule